// File: doc/BRIEF.md
# Masked Data Address Watchpoint

This block holds a small set of data watchpoint slots and compares every memory access on the core's data bus against them. Each slot has a base address and a control word. The control word arms the slot separately for loads and for stores, and carries a low-order mask field. The mask selects an aligned, power-of-two sized region around the base address. An access that falls inside an armed slot's region raises a hit in the same cycle the access is presented, so the core can stop before the access is performed.

Only a mask made of a contiguous run of ones from the most significant bit describes a region. When software writes a mask field that has a hole in it, the block repairs the mask. It keeps the ones above the highest zero bit and clears that bit and every bit below it. The repair is recorded on a sticky error flag, which software clears with a pulse.

Top module: `dwatch_unit`

## Requirements
- R1: After reset every slot is disarmed, so no access produces a hit, and the error flag `mask_err` reads 0.
- R2: Control bit MW (bit 8 at defaults) arms a slot for reads. A read (`acc_write`=0) inside the region hits only when this bit is set.
- R3: Control bit MW+1 (bit 9 at defaults) arms a slot for writes. A write (`acc_write`=1) inside the region hits only when this bit is set.
- R4: A slot with both enable bits clear never hits, whatever its mask and base are.
- R5: The effective mask is the control field bits [MW-1:0] with ones in every bit above them. An access hits a slot when (address AND mask) equals (base AND mask). The region is therefore aligned and its size is the two's complement of the mask.
- R6: When the written mask field is not a run of ones from its top bit, the effective mask keeps the ones above the highest zero bit and is zero from that bit downward.
- R7: `hit` and `hit_vec` are combinational from the access inputs and settle in the cycle the access is presented. With `acc_valid` low they are all zero.
- R8: A control write whose mask field is not contiguous sets `mask_err` from the next cycle on, and the flag stays set until `err_clr` is pulsed. If a setting write and `err_clr` arrive in the same cycle, the set wins.
- R9: A base write (`cfg_we`=1, `cfg_ctrl`=0) takes effect from the next cycle. After it the slot matches around the new address and no longer matches around the old one.
- R10: `hit_vec[i]` reports slot i on its own, and `hit` is the OR of all slots, so overlapping slots can hit together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_slot | input | SW | Slot addressed by the write |
| cfg_ctrl | input | 1 | 1 writes the control word, 0 writes the base address |
| cfg_wdata | input | AW | Write data. For control: [MW-1:0] mask field, [MW] load enable, [MW+1] store enable |
| err_clr | input | 1 | Clears the sticky mask error flag |
| acc_valid | input | 1 | Data access present this cycle |
| acc_write | input | 1 | 1 for a store, 0 for a load |
| acc_addr | input | AW | Access address |
| hit | output | 1 | Some armed slot matches the access |
| hit_vec | output | NSLOT | Per-slot match |
| mask_err | output | 1 | Sticky non-contiguous mask flag |

## Verification
The checker tests on every cycle that no hit appears without a valid access, and that a slot hits only for an access type it has armed. It also checks that `hit` agrees with the per-slot vector and that the error flag rises only after a control write and drops after a lone clear. The region arithmetic can only be shown by the bench's scenarios. These cover region edges just inside and just outside, the repaired mask that widens a region, re-basing a slot and overlapping slots.

// File: rtl/dwatch_unit.sv
module dwatch_unit #(
  parameter int NSLOT = 2,
  parameter int AW    = 32,
  parameter int MW    = 8,
  localparam int SW   = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [SW-1:0]    cfg_slot,
  input  logic             cfg_ctrl,
  input  logic [AW-1:0]    cfg_wdata,
  input  logic             err_clr,
  input  logic             acc_valid,
  input  logic             acc_write,
  input  logic [AW-1:0]    acc_addr,
  output logic             hit,
  output logic [NSLOT-1:0] hit_vec,
  output logic             mask_err
);
  localparam int LD = MW;
  localparam int ST = MW + 1;
  localparam int CW = MW + 2;

  function automatic logic [MW-1:0] trim_mask(input logic [MW-1:0] f);
    logic [MW-1:0] r;
    logic seen;
    seen = 1'b0;
    for (int i = MW - 1; i >= 0; i--) begin
      r[i] = f[i] & ~seen;
      seen = seen | ~f[i];
    end
    return r;
  endfunction

  logic [NSLOT-1:0][CW-1:0] ctrl_q;
  logic [NSLOT-1:0][AW-1:0] base_q;
  logic [MW-1:0] wr_fixed;
  logic          wr_bad;

  assign wr_fixed = trim_mask(cfg_wdata[MW-1:0]);
  assign wr_bad   = cfg_we && cfg_ctrl && (wr_fixed != cfg_wdata[MW-1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      base_q   <= '0;
      mask_err <= 1'b0;
    end else begin
      if (cfg_we && cfg_ctrl)
        ctrl_q[cfg_slot] <= {cfg_wdata[ST], cfg_wdata[LD], wr_fixed};
      if (cfg_we && !cfg_ctrl)
        base_q[cfg_slot] <= cfg_wdata;
      if (wr_bad)
        mask_err <= 1'b1;
      else if (err_clr)
        mask_err <= 1'b0;
    end
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    logic [AW-1:0] m;
    logic          armed;
    assign m     = {{(AW-MW){1'b1}}, ctrl_q[g][MW-1:0]};
    assign armed = acc_write ? ctrl_q[g][ST] : ctrl_q[g][LD];
    assign hit_vec[g] = acc_valid && armed && ((acc_addr & m) == (base_q[g] & m));
  end

  assign hit = |hit_vec;
endmodule

// File: rtl/dwatch_unit_chk.sv
module dwatch_unit_chk #(
  parameter int NSLOT = 2,
  parameter int MW    = 8,
  parameter int SW    = 1
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       cfg_we,
  input logic [SW-1:0]              cfg_slot,
  input logic                       cfg_ctrl,
  input logic                       err_clr,
  input logic                       acc_valid,
  input logic                       acc_write,
  input logic                       hit,
  input logic [NSLOT-1:0]           hit_vec,
  input logic                       mask_err,
  input logic [NSLOT-1:0][MW+1:0]   ctrl_q
);
  assert_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> (hit_vec == '0 && !hit));

  assert_or_R10: assert property (@(posedge clk) disable iff (!rst_n)
    hit == (hit_vec != '0));

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && !cfg_we) |=> !mask_err);

  assert_set_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mask_err) |-> $past(cfg_we && cfg_ctrl && cfg_slot < NSLOT));

  for (genvar g = 0; g < NSLOT; g++) begin : g_chk
    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_vec[g] && !acc_write) |-> ctrl_q[g][MW]);
    assert_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_vec[g] && acc_write) |-> ctrl_q[g][MW+1]);
    assert_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q[g][MW+1:MW] == 2'b00) |-> !hit_vec[g]);
  end
endmodule

bind dwatch_unit dwatch_unit_chk #(.NSLOT(NSLOT), .MW(MW), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_slot(cfg_slot),
  .cfg_ctrl(cfg_ctrl), .err_clr(err_clr), .acc_valid(acc_valid),
  .acc_write(acc_write), .hit(hit), .hit_vec(hit_vec),
  .mask_err(mask_err), .ctrl_q(ctrl_q)
);

// File: tb/tb_dwatch_unit.sv
module tb_dwatch_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [0:0] cfg_slot = '0;
  logic cfg_ctrl = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic err_clr = 1'b0;
  logic acc_valid = 1'b0;
  logic acc_write = 1'b0;
  logic [31:0] acc_addr = '0;
  logic hit;
  logic [1:0] hit_vec;
  logic mask_err;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dwatch_unit dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_slot(cfg_slot),
    .cfg_ctrl(cfg_ctrl), .cfg_wdata(cfg_wdata), .err_clr(err_clr),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
    .hit(hit), .hit_vec(hit_vec), .mask_err(mask_err)
  );

  localparam logic [31:0] LD = 32'h100;
  localparam logic [31:0] ST = 32'h200;

  // {address, write, expected hit_vec}
  localparam logic [34:0] VEC [8] = '{
    {32'h1000_0040, 1'b0, 2'b01},
    {32'h1000_004F, 1'b1, 2'b01},
    {32'h1000_0050, 1'b0, 2'b00},
    {32'h1000_003F, 1'b0, 2'b00},
    {32'h2000_00FF, 1'b1, 2'b10},
    {32'h2000_0010, 1'b0, 2'b00},
    {32'h2000_0100, 1'b1, 2'b00},
    {32'h1000_0044, 1'b1, 2'b01}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input int slot, input bit ctl, input logic [31:0] d, input bit clr = 0);
    @(negedge clk);
    cfg_we = 1'b1; cfg_slot = slot[0:0]; cfg_ctrl = ctl; cfg_wdata = d; err_clr = clr;
    @(negedge clk);
    cfg_we = 1'b0; err_clr = 1'b0;
  endtask

  task automatic acc(input logic [31:0] a, input bit w, input bit v = 1);
    @(negedge clk);
    acc_addr = a; acc_write = w; acc_valid = v;
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    acc(32'h0, 1'b0);
    chk("R1 hit after reset", {31'd0, hit}, 32'd0);
    acc(32'h0, 1'b1);
    chk("R1 write hit after reset", {30'd0, hit_vec}, 32'd0);
    chk("R1 err after reset", {31'd0, mask_err}, 32'd0);

    wr(0, 0, 32'h1000_0040);
    wr(0, 1, LD | ST | 32'hF0);
    wr(1, 0, 32'h2000_0000);
    wr(1, 1, ST | 32'h00);
    for (int i = 0; i < 8; i++) begin
      acc(VEC[i][34:3], VEC[i][2]);
      chk($sformatf("R5 vector %0d", i), {30'd0, hit_vec}, {30'd0, VEC[i][1:0]});
    end
    acc(32'h2000_0010, 1'b0);
    chk("R2 read on store-only slot", {30'd0, hit_vec}, 32'd0);
    acc(32'h2000_0010, 1'b1);
    chk("R3 write on store-only slot", {30'd0, hit_vec}, 32'd2);

    acc(32'h1000_0040, 1'b0, 1'b0);
    chk("R7 no valid", {30'd0, hit_vec}, 32'd0);
    acc(32'h1000_0040, 1'b0, 1'b1);
    chk("R7 same-cycle hit", {31'd0, hit}, 32'd1);

    wr(0, 1, 32'hF0);
    acc(32'h1000_0040, 1'b0);
    chk("R4 disarmed read", {31'd0, hit}, 32'd0);
    acc(32'h1000_0040, 1'b1);
    chk("R4 disarmed write", {31'd0, hit}, 32'd0);
    chk("R8 contiguous leaves err", {31'd0, mask_err}, 32'd0);

    wr(0, 1, LD | 32'hB0);
    chk("R8 err set", {31'd0, mask_err}, 32'd1);
    acc(32'h1000_007F, 1'b0);
    chk("R6 repaired mask widens region", {30'd0, hit_vec}, 32'd1);
    acc(32'h1000_0080, 1'b0);
    chk("R6 outside repaired region", {30'd0, hit_vec}, 32'd0);
    wr(0, 0, 32'h1000_0000, 1);
    chk("R8 err cleared", {31'd0, mask_err}, 32'd0);
    wr(0, 1, LD | 32'hB0, 1);
    chk("R8 set wins over clear", {31'd0, mask_err}, 32'd1);
    repeat (2) @(negedge clk);
    chk("R8 err sticky", {31'd0, mask_err}, 32'd1);

    wr(1, 0, 32'h3000_0000);
    acc(32'h3000_0010, 1'b1);
    chk("R9 new base hits", {30'd0, hit_vec}, 32'd2);
    acc(32'h2000_0010, 1'b1);
    chk("R9 old base misses", {30'd0, hit_vec}, 32'd0);

    wr(0, 0, 32'h3000_0000);
    wr(0, 1, ST | 32'hFF);
    acc(32'h3000_0000, 1'b1);
    chk("R10 both slots", {30'd0, hit_vec}, 32'd3);
    chk("R10 hit or", {31'd0, hit}, 32'd1);
    acc(32'h3000_0001, 1'b1);
    chk("R10 only wide slot", {30'd0, hit_vec}, 32'd2);

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule